// File: doc/BRIEF.md
# Serial Control-Port Register Slave

This block answers a host on a four-wire serial control port. The four wires are an active-low select, a serial clock, data in and a tristate data out. Through them the host reads and writes a small bank of 8-bit mode registers. Each register has a 7-bit address. Every transaction opens with a 16-bit frame. Its first bit picks read or write, the next seven bits carry the address, and the last eight bits carry data. Every field is sent most significant bit first.

A write takes effect only after the host releases select. If the host keeps clocking after the first frame, each further eight clocks carry one more byte for the next address up. A read returns the addressed register on the data-out wire during clocks 9 to 16. The data-out driver is enabled only for those eight clock periods.

The port wires are brought into the system clock domain through synchronizers and edge detection. The bank has a parallel read port for the core. The core also sees a one-cycle update strobe, with address and data, each time a register changes.

Top module: `ctlp_slave`

## Requirements
- R1: After reset every register reads 0x00, the data-out enable is low and no update strobe is raised. While select is high, the frame position returns to its start.
- R2: The port samples serial data on rising serial-clock edges, most significant bit first. Bit 1 is the direction flag (0 = write, 1 = read). Bits 2 to 8 are address bits 6 down to 0. Bits 9 to 16 are data bits 7 down to 0.
- R3: A single write of address A and byte D changes register A only when select rises after the 16th clock. The core then sees one clock cycle of update strobe carrying A and D.
- R4: If select rises after fewer than 16 serial clocks, no register changes and no strobe is raised.
- R5: In a burst, each further byte after the first frame goes to the next address (wrapping from 127 to 0). Each such byte commits at its 8th clock. The first byte commits when select rises. A partial trailing byte is dropped.
- R6: In a read, the data-out enable rises after the falling edge that follows clock 8 and falls after the falling edge that follows clock 16. The register byte appears MSB first and changes on falling edges. Data in is ignored during clocks 9 to 16.
- R7: Only addresses below the bank size exist. Others read back 0x00, and writes to them raise no strobe and change nothing.
- R8: The parallel read port shows a written value from the cycle after its update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sel_n | input | 1 | Port select, active low |
| ctl_sck | input | 1 | Port serial clock |
| ctl_sdi | input | 1 | Port serial data in |
| ctl_sdo | output | 1 | Port serial data out |
| ctl_sdo_oe | output | 1 | Output enable for ctl_sdo |
| host_rd_addr | input | 7 | Parallel read address |
| host_rd_data | output | 8 | Parallel read data (combinational) |
| upd_stb | output | 1 | One-cycle register update strobe |
| upd_addr | output | 7 | Address of the updated register |
| upd_data | output | 8 | Byte written to the updated register |

## Verification
Each edge of a port wire acts inside the block three clock cycles after it is driven: two synchronizer stages and one state stage. The update strobe therefore appears three cycles after the releasing select edge or after the 8th clock of a burst byte. Data out and its enable move three cycles after each falling serial-clock edge, and the parallel read port shows a new value one cycle after the strobe. The bench feeds its behavioural model the port inputs with that same three-cycle delay. It compares every output on each falling system-clock edge, and it samples serial read data at the end of each serial-clock high phase, where the bit is settled.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int CP_AW    = 7;
  localparam int CP_DW    = 8;
  localparam int CP_HDR   = CP_AW + 1;
  localparam int CP_FRAME = CP_HDR + CP_DW;

  typedef logic [CP_AW-1:0] cp_addr_t;
  typedef logic [CP_DW-1:0] cp_data_t;

  // next register address in a burst, wrapping at the top of the space
  function automatic cp_addr_t bump_addr(input cp_addr_t a);
    return a + cp_addr_t'(1);
  endfunction

  // true when an address names an implemented register
  function automatic logic in_bank(input cp_addr_t a, input int n);
    return int'(a) < n;
  endfunction
endpackage

// File: rtl/ctlp_insync.sv
module ctlp_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sck,
  input  logic sdi,
  output logic sel_q,
  output logic sel_rel,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_q
);
  logic [STAGES-1:0] sel_pipe, sck_pipe, sdi_pipe;
  logic sel_last, sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pipe <= '1;
      sck_pipe <= '0;
      sdi_pipe <= '0;
      sel_last <= 1'b1;
      sck_last <= 1'b0;
    end else begin
      sel_pipe <= {sel_pipe[STAGES-2:0], sel_n};
      sck_pipe <= {sck_pipe[STAGES-2:0], sck};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi};
      sel_last <= sel_pipe[STAGES-1];
      sck_last <= sck_pipe[STAGES-1];
    end
  end

  assign sel_q    = sel_pipe[STAGES-1];
  assign sdi_q    = sdi_pipe[STAGES-1];
  assign sel_rel  = sel_q & ~sel_last;
  assign sck_rise = sck_pipe[STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_last;
endmodule

// File: rtl/ctlp_engine.sv
module ctlp_engine
  import ctlp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_q,
  input  logic     sel_rel,
  input  logic     sck_rise,
  input  logic     sck_fall,
  input  logic     sdi_q,
  input  cp_data_t bank_word,
  output cp_addr_t bank_addr,
  output logic     sdo,
  output logic     sdo_oe,
  output logic     wr_stb,
  output cp_addr_t wr_addr,
  output cp_data_t wr_data
);
  localparam int CW = $clog2(CP_FRAME + 1);
  localparam int PW = $clog2(CP_DW);
  localparam logic [CW-1:0] CNT_HDR  = CW'(CP_HDR);
  localparam logic [CW-1:0] CNT_LAST = CW'(CP_FRAME - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(CP_FRAME);
  localparam logic [PW-1:0] POS_LAST = PW'(CP_DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [PW-1:0] byte_pos;
  logic          is_read, pend_vld;
  cp_addr_t      hdr_addr, burst_addr;
  cp_data_t      dshift, pend_data, oshift;

  // named internal events
  logic frame_rise, first_done_ev, burst_ev, release_ev, load_ev;
  cp_data_t byte_done;

  assign frame_rise    = sck_rise & ~sel_q;
  assign byte_done     = {dshift[CP_DW-2:0], sdi_q};
  assign first_done_ev = frame_rise & ~is_read & (bit_cnt == CNT_LAST);
  assign burst_ev      = frame_rise & ~is_read & (bit_cnt == CNT_FULL) & (byte_pos == POS_LAST);
  assign release_ev    = sel_rel & pend_vld;
  assign load_ev       = sck_fall & ~sel_q & is_read & (bit_cnt == CNT_HDR);

  assign bank_addr = hdr_addr;
  assign sdo       = sdo_oe & oshift[CP_DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      byte_pos   <= '0;
      is_read    <= 1'b0;
      pend_vld   <= 1'b0;
      hdr_addr   <= '0;
      burst_addr <= '0;
      dshift     <= '0;
      pend_data  <= '0;
      oshift     <= '0;
      sdo_oe     <= 1'b0;
      wr_stb     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_stb <= burst_ev | release_ev;
      if (burst_ev) begin
        wr_addr <= burst_addr;
        wr_data <= byte_done;
      end else if (release_ev) begin
        wr_addr <= hdr_addr;
        wr_data <= pend_data;
      end

      if (sel_q) begin
        bit_cnt  <= '0;
        byte_pos <= '0;
        is_read  <= 1'b0;
        pend_vld <= 1'b0;
        dshift   <= '0;
        sdo_oe   <= 1'b0;
      end else if (sck_rise) begin
        if (bit_cnt != CNT_FULL) begin
          dshift  <= byte_done;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == '0) is_read <= sdi_q;
          else if (bit_cnt < CNT_HDR) hdr_addr <= {hdr_addr[CP_AW-2:0], sdi_q};
          if (first_done_ev) begin
            pend_vld   <= 1'b1;
            pend_data  <= byte_done;
            burst_addr <= bump_addr(hdr_addr);
          end
        end else if (!is_read) begin
          dshift   <= byte_done;
          byte_pos <= burst_ev ? '0 : byte_pos + 1'b1;
          if (burst_ev) burst_addr <= bump_addr(burst_addr);
        end
      end else if (sck_fall) begin
        if (load_ev) begin
          oshift <= bank_word;
          sdo_oe <= 1'b1;
        end else if (sdo_oe && bit_cnt < CNT_FULL) begin
          oshift <= {oshift[CP_DW-2:0], 1'b0};
        end else if (bit_cnt == CNT_FULL) begin
          sdo_oe <= 1'b0;
        end
      end
    end
  end

  // R6: driver enabled only inside a read
  p_oe_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> is_read);
  // R6: enable opens once the header has been taken in
  p_oe_opens_at_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (bit_cnt == CNT_HDR));
  // R4: release before a full frame leaves no strobe
  p_abort_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rel && bit_cnt < CNT_FULL) |=> !wr_stb);
  // R1: idle select returns the frame to its start
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> (bit_cnt == '0 && byte_pos == '0));
endmodule

// File: rtl/ctlp_regbank.sv
module ctlp_regbank
  import ctlp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  cp_addr_t wr_addr,
  input  cp_data_t wr_data,
  input  cp_addr_t a_addr,
  output cp_data_t a_data,
  input  cp_addr_t b_addr,
  output cp_data_t b_data,
  output logic     upd_stb
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  cp_data_t mem [NUM_REGS];

  assign upd_stb = wr_en & in_bank(wr_addr, NUM_REGS);
  assign a_data  = in_bank(a_addr, NUM_REGS) ? mem[a_addr[IW-1:0]] : '0;
  assign b_data  = in_bank(b_addr, NUM_REGS) ? mem[b_addr[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (upd_stb) begin
      mem[wr_addr[IW-1:0]] <= wr_data;
    end
  end

  // R8: a strobed byte is held in the addressed register next cycle
  p_commit_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> (mem[$past(wr_addr[IW-1:0])] == $past(wr_data)));
endmodule

// File: rtl/ctlp_slave.sv
module ctlp_slave
  import ctlp_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_sel_n,
  input  logic       ctl_sck,
  input  logic       ctl_sdi,
  output logic       ctl_sdo,
  output logic       ctl_sdo_oe,
  input  logic [6:0] host_rd_addr,
  output logic [7:0] host_rd_data,
  output logic       upd_stb,
  output logic [6:0] upd_addr,
  output logic [7:0] upd_data
);
  logic sel_q, sel_rel, sck_rise, sck_fall, sdi_q, eng_stb;
  cp_addr_t eng_addr, bank_addr;
  cp_data_t eng_data, bank_word;

  ctlp_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_n(ctl_sel_n), .sck(ctl_sck), .sdi(ctl_sdi),
    .sel_q(sel_q), .sel_rel(sel_rel), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_q(sdi_q)
  );

  ctlp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sel_rel(sel_rel),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_q(sdi_q),
    .bank_word(bank_word), .bank_addr(bank_addr),
    .sdo(ctl_sdo), .sdo_oe(ctl_sdo_oe),
    .wr_stb(eng_stb), .wr_addr(eng_addr), .wr_data(eng_data)
  );

  ctlp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(eng_stb), .wr_addr(eng_addr), .wr_data(eng_data),
    .a_addr(bank_addr), .a_data(bank_word),
    .b_addr(host_rd_addr), .b_data(host_rd_data),
    .upd_stb(upd_stb)
  );

  assign upd_addr = eng_addr;
  assign upd_data = eng_data;
endmodule

// File: tb/tb_ctlp_slave.sv
module tb_ctlp_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int BANK       = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [6:0] rd_addr = '0;
  logic sdo, sdo_oe, upd_stb;
  logic [6:0] upd_addr;
  logic [7:0] upd_data, rd_data;

  ctlp_slave #(.NUM_REGS(BANK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_sel_n(sel_n), .ctl_sck(sck), .ctl_sdi(sdi),
    .ctl_sdo(sdo), .ctl_sdo_oe(sdo_oe), .host_rd_addr(rd_addr), .host_rd_data(rd_data),
    .upd_stb(upd_stb), .upd_addr(upd_addr), .upd_data(upd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, strobes = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference: the port as seen three system clocks late
  int h_sel[3], h_sck[3], h_sdi[3];
  int m_mem[128];
  int m_cnt, m_read, m_addr, m_sh, m_pend, m_pdata, m_next, m_bpos, m_oe, m_out;
  int m_stb, m_saddr, m_sdata;

  always @(posedge clk) begin
    int cs, csp, ck, ckp, di, n_stb, n_a, n_d;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_sel[i] = 1; h_sck[i] = 0; h_sdi[i] = 0; end
      for (int i = 0; i < 128; i++) m_mem[i] = 0;
      m_cnt = 0; m_read = 0; m_addr = 0; m_sh = 0; m_pend = 0; m_pdata = 0;
      m_next = 0; m_bpos = 0; m_oe = 0; m_out = 0; m_stb = 0; m_saddr = 0; m_sdata = 0;
    end else begin
      cs = h_sel[1]; csp = h_sel[2]; ck = h_sck[1]; ckp = h_sck[2]; di = h_sdi[1];
      n_stb = 0; n_a = 0; n_d = 0;
      if (cs != 0) begin
        if (csp == 0 && m_pend != 0) begin n_stb = 1; n_a = m_addr; n_d = m_pdata; end
        m_cnt = 0; m_read = 0; m_pend = 0; m_bpos = 0; m_oe = 0; m_sh = 0;
      end else if (ck != 0 && ckp == 0) begin
        if (m_cnt < 16) begin
          if (m_cnt == 0) m_read = di;
          else if (m_cnt < 8) m_addr = (m_addr * 2 + di) % 128;
          m_sh = (m_sh * 2 + di) % 256;
          if (m_cnt == 15 && m_read == 0) begin
            m_pend = 1; m_pdata = m_sh; m_next = (m_addr + 1) % 128;
          end
          m_cnt++;
        end else if (m_read == 0) begin
          m_sh = (m_sh * 2 + di) % 256;
          m_bpos++;
          if (m_bpos == 8) begin
            n_stb = 1; n_a = m_next; n_d = m_sh;
            m_next = (m_next + 1) % 128; m_bpos = 0;
          end
        end
      end else if (ck == 0 && ckp != 0) begin
        if (m_read != 0 && m_cnt == 8) begin
          m_oe = 1; m_out = (m_addr < BANK) ? m_mem[m_addr] : 0;
        end else if (m_oe != 0 && m_cnt < 16) begin
          m_out = (m_out * 2) % 256;
        end else if (m_cnt == 16) begin
          m_oe = 0;
        end
      end
      if (m_stb != 0) m_mem[m_saddr] = m_sdata;
      m_stb = (n_stb != 0 && n_a < BANK) ? 1 : 0;
      m_saddr = n_a; m_sdata = n_d;
      h_sel[2] = h_sel[1]; h_sel[1] = h_sel[0]; h_sel[0] = int'(sel_n);
      h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = int'(sck);
      h_sdi[2] = h_sdi[1]; h_sdi[1] = h_sdi[0]; h_sdi[0] = int'(sdi);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    int e_sdo, e_rd;
    if (rst_n && !done) begin
      checks++;
      e_sdo = (m_oe != 0) ? ((m_out >> 7) & 1) : 0;
      e_rd  = (rd_addr < BANK) ? m_mem[rd_addr] : 0;
      if (int'(sdo_oe) != m_oe || int'(sdo) != e_sdo) begin
        errors++;
        $display("FAIL R6 (%s) t=%0t: oe/sdo actual %0d/%0d expected %0d/%0d",
                 tag, $time, sdo_oe, sdo, m_oe, e_sdo);
      end else if (int'(upd_stb) != m_stb ||
                   (m_stb != 0 && (int'(upd_addr) != m_saddr || int'(upd_data) != m_sdata))) begin
        errors++;
        $display("FAIL R3 (%s) t=%0t: stb/addr/data actual %0d/%h/%h expected %0d/%h/%h",
                 tag, $time, upd_stb, upd_addr, upd_data, m_stb, m_saddr, m_sdata);
      end else if (int'(rd_data) != e_rd) begin
        errors++;
        $display("FAIL R8 (%s) t=%0t: rd_data[%h] actual %h expected %h",
                 tag, $time, rd_addr, rd_data, e_rd);
      end
      if (upd_stb) strobes++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive n bits MSB first from bits[n-1]; cap collects data out per bit
  task automatic send(input logic [63:0] bits, input int n, output logic [63:0] cap);
    cap = '0;
    sel_n = 1'b0;
    tick(HALF_BIT);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; sdi = bits[n-1-i];
      tick(HALF_BIT);
      sck = 1'b1;
      tick(HALF_BIT);
      cap = {cap[62:0], sdo};
    end
    sck = 1'b0;
    tick(HALF_BIT);
    sel_n = 1'b1;
    tick(10);
  endtask

  task automatic peek(input int a, input int exp, input string req);
    rd_addr = 7'(a);
    tick(1);
    chk(req, int'(rd_data), exp, $sformatf("port reg %h", a));
  endtask

  logic [63:0] cap;
  int s0;

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);

    tag = "R1";
    chk("R1", int'(sdo_oe), 0, "oe after reset");
    chk("R1", int'(upd_stb), 0, "strobe after reset");
    for (int a = 0; a < BANK; a++) peek(a, 0, "R1");

    tag = "R3";
    s0 = strobes;
    send({48'd0, 1'b0, 7'h03, 8'hA5}, 16, cap);
    chk("R3", strobes - s0, 1, "single write strobes");
    peek(3, 8'hA5, "R3");

    tag = "R2";
    send({48'd0, 1'b0, 7'h01, 8'h80}, 16, cap);
    peek(1, 8'h80, "R2");
    send({48'd0, 1'b1, 7'h01, 8'h00}, 16, cap);
    chk("R2", int'(cap[7:0]), 8'h80, "read-back MSB first");

    tag = "R6";
    send({48'd0, 1'b1, 7'h03, 8'hFF}, 16, cap);
    chk("R6", int'(cap[7:0]), 8'hA5, "read with ones on data in");
    send({48'd0, 1'b1, 7'h03, 8'h5A}, 16, cap);
    chk("R6", int'(cap[7:0]), 8'hA5, "read with pattern on data in");
    chk("R6", int'(sdo_oe), 0, "oe low after read");
    peek(3, 8'hA5, "R6");

    tag = "R4";
    s0 = strobes;
    send({54'd0, 10'b0_0000110_10}, 10, cap);
    send({49'd0, 15'b0_0000110_1111111}, 15, cap);
    chk("R4", strobes - s0, 0, "aborted frames strobes");
    peek(6, 0, "R4");

    tag = "R5";
    s0 = strobes;
    send({21'd0, 1'b0, 7'h08, 8'hA1, 8'hB2, 8'hC3, 5'b11111}, 37, cap);
    chk("R5", strobes - s0, 3, "burst strobes");
    peek(8, 8'hA1, "R5");
    peek(9, 8'hB2, "R5");
    peek(10, 8'hC3, "R5");
    peek(11, 0, "R5");

    tag = "R7";
    s0 = strobes;
    send({40'd0, 1'b0, 7'h0F, 8'h5E, 8'h6F}, 24, cap);
    chk("R7", strobes - s0, 1, "burst past bank end strobes");
    peek(15, 8'h5E, "R7");
    s0 = strobes;
    send({48'd0, 1'b0, 7'h40, 8'h77}, 16, cap);
    chk("R7", strobes - s0, 0, "write to missing register");
    send({48'd0, 1'b1, 7'h40, 8'h00}, 16, cap);
    chk("R7", int'(cap[7:0]), 0, "read of missing register");
    peek(7'h7F, 0, "R7");

    tag = "R8";
    send({48'd0, 1'b0, 7'h03, 8'h3C}, 16, cap);
    peek(3, 8'h3C, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule